// File: doc/BRIEF.md
# Multi-Rail Power Sequencing Controller

This block turns on and shuts off a group of supply rails in a fixed order. It works only from digital status flags. Analog comparators report whether the input bus is above its hold-up (lockout) level and its cut-off (shutdown) level, and whether each rail is above its undervoltage level. Three more flags report faults: the die is too hot, the charge pump is low, or the internal bias supply is low. A register interface supplies one enable bit each for the 5 V rail, the two linear rails and the motor rail. All time is counted in cycles of the digital timing clock.

The order of power-up is fixed:

1. The core rail starts first and gets a soft-start window.
2. The 3.3 V and 2.5 V rails then start together.
3. Once all three are good, the secondary rails (5 V, the two linear rails and the motor rail) start. At the same time a long power-on delay begins; when it ends, the power-on-sense flag rises.

Power-good adds one more condition to power-on-sense: the input bus must be above its lockout level. Because the lockout and shutdown levels are handled separately, there is a hold-up interval: power-good drops while the rails are still on. Any fault condition, including the bus falling below shutdown, turns every channel off. When the fault clears, the whole sequence restarts on its own.

Top module: `rail_seq_ctrl`

## Requirements
- R1: While `rst` is high, and on the first sample after it falls, every rail enable, every `ss_start` bit, `por_sense` and `pwr_good` are 0.
- R2: No rail is enabled while `bus_above_shdn` is 0, whatever the other flags are.
- R3: `en_core` rises first. `en_33` and `en_25` rise together, exactly `SS_CYCLES` clock cycles after `en_core`, and only once the core rail reports good. While `core_uv_ok` stays 0, they stay off indefinitely.
- R4: The secondary rails are enabled one cycle after the 3.3 V and 2.5 V enables, provided core, 3.3 V and 2.5 V all report good. `por_sense` rises exactly `POR_CYCLES` cycles after the secondary enables.
- R5: `cfg_v5_en` individually gates `en_v5`, and `cfg_mot_en` gates `en_mot`. `cfg_lin1_en` and `cfg_lin2_en` gate the two linear rails. None of these bits affects the other outputs.
- R6: `en_lin1` and `en_lin2` may be 1 only while `en_v5` is 1 and `v5_uv_ok` reports good.
- R7: `pwr_good` is 1 only while `por_sense` is 1 and `bus_above_lock` is 1. When the lockout flag drops, `pwr_good` falls and every rail stays enabled.
- R8: When `bus_above_shdn` drops, every rail enable goes to 0. When it returns, bring-up restarts from the core rail.
- R9: When core, 3.3 V or 2.5 V drops below its undervoltage level, `por_sense` and `pwr_good` fall and the rails stay enabled. Once the rail recovers, the full `POR_CYCLES` delay runs again.
- R10: `over_temp`, `cp_uv` or `bias_uv` turns every rail off. When the flag clears, the full sequence restarts, including the core soft-start window.
- R11: `ss_start[i]` is a pulse one cycle long, in the cycle in which enable i first reads 1. Bit order: 0 core, 1 3.3 V, 2 2.5 V, 3 5 V, 4 linear 1, 5 linear 2, 6 motor.
- R12: Each comparator flag passes through a two-flop synchronizer. A flag change made between clock edges shows up at the outputs after the third rising edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Digital timing clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_above_shdn | input | 1 | Input bus above the shutdown level (async) |
| bus_above_lock | input | 1 | Input bus above the lockout level (async) |
| core_uv_ok | input | 1 | Core rail above its undervoltage level (async) |
| r33_uv_ok | input | 1 | 3.3 V rail above its undervoltage level (async) |
| r25_uv_ok | input | 1 | 2.5 V rail above its undervoltage level (async) |
| v5_uv_ok | input | 1 | 5 V rail above its undervoltage level (async) |
| over_temp | input | 1 | Thermal shutdown condition (async) |
| cp_uv | input | 1 | Charge pump undervoltage (async) |
| bias_uv | input | 1 | Bias regulator undervoltage (async) |
| cfg_v5_en | input | 1 | Register enable bit for the 5 V rail |
| cfg_lin1_en | input | 1 | Register enable bit for linear rail 1 |
| cfg_lin2_en | input | 1 | Register enable bit for linear rail 2 |
| cfg_mot_en | input | 1 | Register enable bit for the motor rail |
| en_core | output | 1 | Core rail enable |
| en_33 | output | 1 | 3.3 V rail enable |
| en_25 | output | 1 | 2.5 V rail enable |
| en_v5 | output | 1 | 5 V rail enable |
| en_lin1 | output | 1 | Linear rail 1 enable |
| en_lin2 | output | 1 | Linear rail 2 enable |
| en_mot | output | 1 | Motor rail enable |
| ss_start | output | 7 | Soft-start request pulses, one per rail |
| por_sense | output | 1 | Power-on-sense flag |
| pwr_good | output | 1 | Power-good flag |

## Verification
A state machine stuck in, or skipping, a stage shows at the ports as an enable that rises out of order. It can also show as a soft-start gap or power-on delay that differs from the parameter value by even a single cycle, so the bench measures both intervals exactly. A fault or undervoltage path wired to the wrong state appears three edges after the flag changes: either an enable that fails to drop, or a `por_sense` that stays high. A timer that is not reloaded shows up as a `por_sense` that returns too early after a rail dip.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_CORE_SS,
    ST_RAIL_RAMP,
    ST_POR_WAIT,
    ST_RUN
  } seq_state_e;

  // rail indices inside the enable / soft-start vectors
  localparam int RAIL_CORE = 0;
  localparam int RAIL_33   = 1;
  localparam int RAIL_25   = 2;
  localparam int RAIL_V5   = 3;
  localparam int RAIL_LIN1 = 4;
  localparam int RAIL_LIN2 = 5;
  localparam int RAIL_MOT  = 6;
  localparam int NUM_RAILS = 7;

  // flag indices inside the synchronized flag vector
  localparam int FL_SHDN   = 0;
  localparam int FL_LOCK   = 1;
  localparam int FL_CORE   = 2;
  localparam int FL_33     = 3;
  localparam int FL_25     = 4;
  localparam int FL_V5     = 5;
  localparam int FL_OT     = 6;
  localparam int FL_CP     = 7;
  localparam int FL_BIAS   = 8;
  localparam int NUM_FLAGS = 9;

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  // reset to 0: a low flag reads as "not good" or "no fault", and the
  // shutdown-level flag low keeps the sequencer off
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int TW = 19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm
  import rail_seq_pkg::*;
#(
  parameter int SS_CYCLES  = 10000,
  parameter int POR_CYCLES = 300000,
  parameter int TW         = 19
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] flags_s,
  input  logic                 cfg_v5_en,
  input  logic                 cfg_lin1_en,
  input  logic                 cfg_lin2_en,
  input  logic                 cfg_mot_en,
  input  logic                 tmr_done,
  output logic                 tmr_load,
  output logic [TW-1:0]        tmr_val,
  output logic [NUM_RAILS-1:0] rail_en,
  output logic [NUM_RAILS-1:0] ss_start,
  output logic                 por_sense,
  output logic                 pwr_good
);

  localparam logic [TW-1:0] SS_LOAD  = TW'(SS_CYCLES - 1);
  localparam logic [TW-1:0] POR_LOAD = TW'(POR_CYCLES - 1);

  seq_state_e state_q, state_d;
  logic [NUM_RAILS-1:0] en_d;
  logic fault, rails_ok;
  logic base_on, mid_on, late_on;

  assign fault    = flags_s[FL_OT] | flags_s[FL_CP] | flags_s[FL_BIAS] | ~flags_s[FL_SHDN];
  assign rails_ok = flags_s[FL_CORE] & flags_s[FL_33] & flags_s[FL_25];

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = SS_LOAD;
    case (state_q)
      ST_OFF: begin
        state_d  = ST_CORE_SS;
        tmr_load = 1'b1;
        tmr_val  = SS_LOAD;
      end
      ST_CORE_SS: begin
        if (tmr_done && flags_s[FL_CORE]) state_d = ST_RAIL_RAMP;
      end
      ST_RAIL_RAMP: begin
        if (rails_ok) begin
          state_d  = ST_POR_WAIT;
          tmr_load = 1'b1;
          tmr_val  = POR_LOAD;
        end
      end
      ST_POR_WAIT: begin
        if (!rails_ok) begin
          tmr_load = 1'b1;
          tmr_val  = POR_LOAD;
        end else if (tmr_done) begin
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!rails_ok) begin
          state_d  = ST_POR_WAIT;
          tmr_load = 1'b1;
          tmr_val  = POR_LOAD;
        end
      end
      default: state_d = ST_OFF;
    endcase
    if (fault) begin
      state_d  = ST_OFF;
      tmr_load = 1'b0;
    end
  end

  assign base_on = (state_d != ST_OFF);
  assign mid_on  = (state_d inside {ST_RAIL_RAMP, ST_POR_WAIT, ST_RUN});
  assign late_on = (state_d inside {ST_POR_WAIT, ST_RUN});

  always_comb begin
    en_d            = '0;
    en_d[RAIL_CORE] = base_on;
    en_d[RAIL_33]   = mid_on;
    en_d[RAIL_25]   = mid_on;
    en_d[RAIL_V5]   = late_on & cfg_v5_en;
    en_d[RAIL_MOT]  = late_on & cfg_mot_en;
    en_d[RAIL_LIN1] = late_on & cfg_v5_en & flags_s[FL_V5] & cfg_lin1_en;
    en_d[RAIL_LIN2] = late_on & cfg_v5_en & flags_s[FL_V5] & cfg_lin2_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_OFF;
      rail_en   <= '0;
      ss_start  <= '0;
      por_sense <= 1'b0;
      pwr_good  <= 1'b0;
    end else begin
      state_q   <= state_d;
      rail_en   <= en_d;
      ss_start  <= en_d & ~rail_en;
      por_sense <= (state_d == ST_RUN);
      pwr_good  <= (state_d == ST_RUN) & flags_s[FL_LOCK];
    end
  end

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
#(
  parameter int SS_CYCLES   = 10000,
  parameter int POR_CYCLES  = 300000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_above_shdn,
  input  logic       bus_above_lock,
  input  logic       core_uv_ok,
  input  logic       r33_uv_ok,
  input  logic       r25_uv_ok,
  input  logic       v5_uv_ok,
  input  logic       over_temp,
  input  logic       cp_uv,
  input  logic       bias_uv,
  input  logic       cfg_v5_en,
  input  logic       cfg_lin1_en,
  input  logic       cfg_lin2_en,
  input  logic       cfg_mot_en,
  output logic       en_core,
  output logic       en_33,
  output logic       en_25,
  output logic       en_v5,
  output logic       en_lin1,
  output logic       en_lin2,
  output logic       en_mot,
  output logic [6:0] ss_start,
  output logic       por_sense,
  output logic       pwr_good
);

  localparam int CNT_MAX = (SS_CYCLES > POR_CYCLES) ? SS_CYCLES : POR_CYCLES;
  localparam int TW      = $clog2(CNT_MAX + 1);

  logic [NUM_FLAGS-1:0] flags_raw, flags_s;
  logic [NUM_RAILS-1:0] rail_en_w;
  logic                 tmr_load, tmr_done;
  logic [TW-1:0]        tmr_val;

  always_comb begin
    flags_raw          = '0;
    flags_raw[FL_SHDN] = bus_above_shdn;
    flags_raw[FL_LOCK] = bus_above_lock;
    flags_raw[FL_CORE] = core_uv_ok;
    flags_raw[FL_33]   = r33_uv_ok;
    flags_raw[FL_25]   = r25_uv_ok;
    flags_raw[FL_V5]   = v5_uv_ok;
    flags_raw[FL_OT]   = over_temp;
    flags_raw[FL_CP]   = cp_uv;
    flags_raw[FL_BIAS] = bias_uv;
  end

  flag_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (flags_raw),
    .dout (flags_s)
  );

  seq_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  rail_seq_fsm #(
    .SS_CYCLES  (SS_CYCLES),
    .POR_CYCLES (POR_CYCLES),
    .TW         (TW)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .flags_s     (flags_s),
    .cfg_v5_en   (cfg_v5_en),
    .cfg_lin1_en (cfg_lin1_en),
    .cfg_lin2_en (cfg_lin2_en),
    .cfg_mot_en  (cfg_mot_en),
    .tmr_done    (tmr_done),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .rail_en     (rail_en_w),
    .ss_start    (ss_start),
    .por_sense   (por_sense),
    .pwr_good    (pwr_good)
  );

  assign en_core = rail_en_w[RAIL_CORE];
  assign en_33   = rail_en_w[RAIL_33];
  assign en_25   = rail_en_w[RAIL_25];
  assign en_v5   = rail_en_w[RAIL_V5];
  assign en_lin1 = rail_en_w[RAIL_LIN1];
  assign en_lin2 = rail_en_w[RAIL_LIN2];
  assign en_mot  = rail_en_w[RAIL_MOT];

endmodule

// File: rtl/rail_seq_ctrl_chk.sv
module rail_seq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_above_shdn,
  input logic       bus_above_lock,
  input logic       over_temp,
  input logic       cp_uv,
  input logic       bias_uv,
  input logic       en_core,
  input logic       en_33,
  input logic       en_25,
  input logic       en_v5,
  input logic       en_lin1,
  input logic       en_lin2,
  input logic       en_mot,
  input logic [6:0] ss_start,
  input logic       por_sense,
  input logic       pwr_good
);

  logic [6:0] en_vec;
  assign en_vec = {en_mot, en_lin2, en_lin1, en_v5, en_25, en_33, en_core};

  assert_rst_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (en_vec == 7'd0) && !por_sense && !pwr_good);

  assert_stage_order_R3: assert property (@(posedge clk) disable iff (rst)
    (en_33 || en_25) |-> en_core && (en_33 == en_25));

  assert_por_needs_rails_R4: assert property (@(posedge clk) disable iff (rst)
    por_sense |-> en_core && en_33 && en_25);

  assert_lin_needs_v5_R6: assert property (@(posedge clk) disable iff (rst)
    (en_lin1 || en_lin2) |-> en_v5);

  assert_pg_needs_por_R7: assert property (@(posedge clk) disable iff (rst)
    pwr_good |-> por_sense);

  assert_shdn_off_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!bus_above_shdn, 2) |=> (en_vec == 7'd0));

  assert_fault_off_R10: assert property (@(posedge clk) disable iff (rst)
    $past(over_temp || cp_uv || bias_uv, 2) |=> (en_vec == 7'd0));

  assert_ss_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    (ss_start != 7'd0) |-> ((ss_start & ~en_vec) == 7'd0) &&
                          ((ss_start & $past(en_vec)) == 7'd0));

endmodule

bind rail_seq_ctrl rail_seq_ctrl_chk u_chk (.*);

// File: tb/rail_seq_ctrl_tb.sv
module rail_seq_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SS  = 8;
  localparam int POR = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_above_shdn = 0, bus_above_lock = 0;
  logic core_uv_ok = 0, r33_uv_ok = 0, r25_uv_ok = 0, v5_uv_ok = 0;
  logic over_temp = 0, cp_uv = 0, bias_uv = 0;
  logic cfg_v5_en = 1, cfg_lin1_en = 1, cfg_lin2_en = 1, cfg_mot_en = 1;
  logic en_core, en_33, en_25, en_v5, en_lin1, en_lin2, en_mot;
  logic [6:0] ss_start;
  logic por_sense, pwr_good;
  logic [8:0] obs;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_seq_ctrl #(.SS_CYCLES(SS), .POR_CYCLES(POR), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst),
    .bus_above_shdn(bus_above_shdn), .bus_above_lock(bus_above_lock),
    .core_uv_ok(core_uv_ok), .r33_uv_ok(r33_uv_ok), .r25_uv_ok(r25_uv_ok),
    .v5_uv_ok(v5_uv_ok), .over_temp(over_temp), .cp_uv(cp_uv), .bias_uv(bias_uv),
    .cfg_v5_en(cfg_v5_en), .cfg_lin1_en(cfg_lin1_en), .cfg_lin2_en(cfg_lin2_en),
    .cfg_mot_en(cfg_mot_en),
    .en_core(en_core), .en_33(en_33), .en_25(en_25), .en_v5(en_v5),
    .en_lin1(en_lin1), .en_lin2(en_lin2), .en_mot(en_mot),
    .ss_start(ss_start), .por_sense(por_sense), .pwr_good(pwr_good)
  );

  // bits: 0 core, 1 r33, 2 r25, 3 v5, 4 lin1, 5 lin2, 6 mot, 7 por, 8 pg
  assign obs = {pwr_good, por_sense, en_mot, en_lin2, en_lin1, en_v5, en_25, en_33, en_core};

  // {cfg_v5, cfg_mot, cfg_lin1, cfg_lin2, lock, v5_ok} _ {v5, mot, lin1, lin2, pg, por}
  localparam logic [11:0] VEC [10] = '{
    12'b111111_111111,
    12'b011111_010011,
    12'b101111_101111,
    12'b110111_110111,
    12'b111011_111011,
    12'b111110_110011,
    12'b111101_111101,
    12'b111111_111111,
    12'b000011_000011,
    12'b111111_111111
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_high(input int idx, output int cnt);
    cnt = 0;
    do begin
      step(1);
      cnt++;
    end while (!obs[idx] && cnt < 1000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    step(3);
    check("R1 outputs in reset", {23'd0, obs}, 32'd0);
    rst = 1'b0;
    step(1);
    check("R1 outputs after reset", {25'd0, ss_start}, 32'd0);

    // R2: everything good except the shutdown-level flag
    bus_above_lock = 1; core_uv_ok = 1; r33_uv_ok = 1; r25_uv_ok = 1; v5_uv_ok = 1;
    step(10);
    check("R2 held off below shutdown", {23'd0, obs}, 32'd0);

    // bring-up
    bus_above_shdn = 1;
    wait_high(0, cnt);
    check("R12 core enable latency", cnt, 3);
    check("R11 core soft-start pulse", {25'd0, ss_start}, 32'h01);
    wait_high(1, cnt);
    check("R3 core to 3.3V gap", cnt, SS);
    check("R3 2.5V with 3.3V", {31'd0, en_25}, 1);
    check("R11 3.3/2.5 pulses", {25'd0, ss_start}, 32'h06);
    wait_high(3, cnt);
    check("R4 secondary one cycle later", cnt, 1);
    check("R11 secondary pulses", {25'd0, ss_start}, 32'h78);
    wait_high(7, cnt);
    check("R4 power-on delay", cnt, POR);
    check("R7 power-good with por", {31'd0, pwr_good}, 1);
    step(1);
    check("R11 pulses one cycle", {25'd0, ss_start}, 32'h00);

    // table: R5 R6 R7 register gating and lockout behaviour in run
    for (int i = 0; i < 10; i++) begin
      {cfg_v5_en, cfg_mot_en, cfg_lin1_en, cfg_lin2_en, bus_above_lock, v5_uv_ok} = VEC[i][11:6];
      step(4);
      check($sformatf("R5 R6 R7 vector %0d", i),
            {26'd0, en_v5, en_mot, en_lin1, en_lin2, pwr_good, por_sense},
            {26'd0, VEC[i][5:0]});
      check($sformatf("R7 base rails stay on vector %0d", i), {29'd0, obs[2:0]}, 32'h7);
    end

    // R9 rail dip
    r33_uv_ok = 0;
    step(2);
    check("R12 por before third edge", {31'd0, por_sense}, 1);
    step(1);
    check("R9 por and pg drop", {30'd0, pwr_good, por_sense}, 0);
    check("R9 rails stay enabled", {25'd0, obs[6:0]}, 32'h7F);
    r33_uv_ok = 1;
    wait_high(7, cnt);
    check("R9 full delay after dip", cnt, POR + 2);

    // R8 shutdown level
    bus_above_shdn = 0;
    step(3);
    check("R8 all off", {23'd0, obs}, 0);
    step(10);
    check("R8 stays off", {23'd0, obs}, 0);
    bus_above_shdn = 1;
    step(2);
    check("R12 restart not before third edge", {31'd0, en_core}, 0);
    step(1);
    check("R8 restart from core", {25'd0, obs[6:0]}, 32'h01);
    wait_high(7, cnt);
    check("R8 back to run", {23'd0, obs}, 32'h1FF);

    // R10 faults
    over_temp = 1;
    step(3);
    check("R10 overtemp off", {23'd0, obs}, 0);
    step(20);
    check("R10 overtemp holds off", {23'd0, obs}, 0);
    core_uv_ok = 0;
    over_temp = 0;
    step(3);
    check("R10 restart core", {25'd0, obs[6:0]}, 32'h01);
    step(SS + 10);
    check("R3 hold without core good", {25'd0, obs[6:0]}, 32'h01);
    core_uv_ok = 1;
    step(3);
    check("R3 3.3/2.5 after core good", {29'd0, obs[2:0]}, 32'h7);
    wait_high(7, cnt);
    cp_uv = 1;
    step(3);
    check("R10 charge pump off", {23'd0, obs}, 0);
    cp_uv = 0;
    step(3);
    check("R10 charge pump restart", {25'd0, obs[6:0]}, 32'h01);
    bias_uv = 1;
    step(3);
    check("R10 bias off", {23'd0, obs}, 0);
    bias_uv = 0;
    wait_high(7, cnt);
    check("R10 full recovery", {23'd0, obs}, 32'h1FF);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule